// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches the running minutes, hours and day-of-week fields of a real-time clock. It compares them against three programmable alarm registers once per minute rollover. Each alarm register carries its own "don't care" bit, so the alarm can match on any mix of fields. When every field that takes part matches, a time-of-day flag is set. A second flag records watchdog events that arrive from a counter outside this block.

Both flags sit in a command register. The same register holds one mask bit for each source, a bit that picks level or pulse signalling, and a bit that swaps which of the two active-low interrupt pins carries which source. A third interrupt pin follows pin A, and a software force bit can hold it low at any time. The host reads the command register to see which source fired, and that read clears both flags.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset, the alarm registers read 0x00 and the force register reads 0x00. The command register reads 0x0C, which means both masks are set and both flags are clear. All three interrupt pins are high.
- R2: Registers are written at the address in the same cycle that reg_wr is high. Minute alarm is at 0x03, hour alarm at 0x05 and day alarm at 0x07; each is 8 bits and reads back in full. The force register at 0x08 keeps only bit 7. The command register is at 0x0B. Any other address reads 0x00. reg_rdata shows the register currently selected by reg_addr.
- R3: On a clock edge where minute_tick is high, each alarm field is compared with its time input on bits 6:0. A field with bit 7 set is left out of the compare. If every field matches, the time-of-day flag (command bit 0) is set on that edge.
- R4: The flag is never set while minute_tick is low, even when the fields match. If all three mask bits are set, every minute_tick sets the flag.
- R5: The watchdog flag (command bit 1) is set on each edge where wdog_evt is high. Writes to the command register change only bits 2 to 5: time-of-day mask on bit 2, watchdog mask on bit 3, pulse mode on bit 4, pin swap on bit 5. Bits 0 and 1 are not changed by writes.
- R6: A cycle with reg_rd high and reg_addr at 0x0B clears both flags on that edge. If a set event for a flag falls in the same cycle, that flag stays set.
- R7: In level mode (bit 4 = 0), a source's interrupt line is active for as long as its flag is set and its mask bit is clear. Setting the mask later releases the line.
- R8: In pulse mode (bit 4 = 1), a source's line is active for exactly PULSE_LEN cycles. The pulse starts on the edge where the flag goes from clear to set while the mask is clear. A command read ends a running pulse.
- R9: With bit 5 = 0, irq_a_n carries the time-of-day line and irq_b_n carries the watchdog line. With bit 5 = 1, the two lines are swapped. Both pins are active low.
- R10: irq_p_n equals irq_a_n while force bit 7 is 0, and is held low while force bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD in the clock's 12/24 format |
| cur_day | input | 8 | Current day of week, 1 to 7 |
| minute_tick | input | 1 | One-cycle strobe at minute rollover |
| wdog_evt | input | 1 | Watchdog expiry event from the external counter |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags when it reads the command register) |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| tod_flag | output | 1 | Time-of-day alarm flag |
| wd_flag | output | 1 | Watchdog alarm flag |
| irq_a_n | output | 1 | Interrupt pin A, active low |
| irq_b_n | output | 1 | Interrupt pin B, active low |
| irq_p_n | output | 1 | Interrupt pin P, active low, can be forced low |

## Verification
The hardest case to reach from the ports is a command read that lands in the same cycle as a minute_tick whose fields match while the flag is already set. That cycle has to keep the flag set and must not start a new pulse. The stimulus first sets the flag, then issues the read and the matching tick together. It does this in pulse mode, so that a stray restart of the pulse counter would show on the pin. A reference model runs beside the design cycle by cycle and compares every output each clock. This also catches release timing on the pins and the pin swap.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int N_FIELD = 3;

  localparam logic [ADDR_W-1:0] A_ALM_MIN  = 6'h03;
  localparam logic [ADDR_W-1:0] A_ALM_HOUR = 6'h05;
  localparam logic [ADDR_W-1:0] A_ALM_DAY  = 6'h07;
  localparam logic [ADDR_W-1:0] A_FORCE    = 6'h08;
  localparam logic [ADDR_W-1:0] A_CMD      = 6'h0B;

  localparam int B_TDF   = 0;
  localparam int B_WAF   = 1;
  localparam int B_TDM   = 2;
  localparam int B_WAM   = 3;
  localparam int B_PULSE = 4;
  localparam int B_SEL   = 5;

  typedef struct packed {
    logic sel;
    logic pulse;
    logic wam;
    logic tdm;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{sel: 1'b0, pulse: 1'b0, wam: 1'b1, tdm: 1'b1};
endpackage

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic [N_FIELD-1:0][DATA_W-1:0] cur_f,
  input  logic [N_FIELD-1:0][DATA_W-1:0] alm_f,
  output logic                           hit
);
  localparam int VAL_MSB = DATA_W - 2;

  logic [N_FIELD-1:0] fld_ok;

  generate
    for (genvar gi = 0; gi < N_FIELD; gi++) begin : g_field
      logic dont_care;
      logic equal;
      assign dont_care  = alm_f[gi][DATA_W-1];
      assign equal      = (alm_f[gi][VAL_MSB:0] == cur_f[gi][VAL_MSB:0]);
      assign fld_ok[gi] = dont_care | equal;
    end
  endgenerate

  assign hit = &fld_ok;
endmodule

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  input  logic                           minute_tick,
  input  logic                           hit,
  input  logic                           wdog_evt,
  output logic [N_FIELD-1:0][DATA_W-1:0] alm_f,
  output logic                           force_p,
  output ctrl_t                          ctrl,
  output logic                           tdf,
  output logic                           waf,
  output logic                           tod_fire,
  output logic                           wd_fire,
  output logic                           flag_clr,
  output logic [DATA_W-1:0]              reg_rdata
);
  logic [N_FIELD-1:0][DATA_W-1:0] alm_q, alm_nx;
  logic  force_q, force_nx;
  ctrl_t ctrl_q, ctrl_nx;
  logic  tdf_q, tdf_nx, waf_q, waf_nx;
  logic  tod_set;

  assign tod_set  = minute_tick & hit;
  assign flag_clr = reg_rd & (reg_addr == A_CMD);
  assign tod_fire = tod_set & ~tdf_q & ~ctrl_q.tdm;
  assign wd_fire  = wdog_evt & ~waf_q & ~ctrl_q.wam;

  always_comb begin
    alm_nx   = alm_q;
    force_nx = force_q;
    ctrl_nx  = ctrl_q;
    tdf_nx   = tdf_q;
    waf_nx   = waf_q;
    if (reg_wr) begin
      case (reg_addr)
        A_ALM_MIN:  alm_nx[0] = reg_wdata;
        A_ALM_HOUR: alm_nx[1] = reg_wdata;
        A_ALM_DAY:  alm_nx[2] = reg_wdata;
        A_FORCE:    force_nx  = reg_wdata[DATA_W-1];
        A_CMD: begin
          ctrl_nx.tdm   = reg_wdata[B_TDM];
          ctrl_nx.wam   = reg_wdata[B_WAM];
          ctrl_nx.pulse = reg_wdata[B_PULSE];
          ctrl_nx.sel   = reg_wdata[B_SEL];
        end
        default: ;
      endcase
    end
    if (flag_clr) begin
      tdf_nx = 1'b0;
      waf_nx = 1'b0;
    end
    if (tod_set)  tdf_nx = 1'b1;
    if (wdog_evt) waf_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q   <= '0;
      force_q <= 1'b0;
      ctrl_q  <= CTRL_RST;
      tdf_q   <= 1'b0;
      waf_q   <= 1'b0;
    end else begin
      alm_q   <= alm_nx;
      force_q <= force_nx;
      ctrl_q  <= ctrl_nx;
      tdf_q   <= tdf_nx;
      waf_q   <= waf_nx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ALM_MIN:  reg_rdata = alm_q[0];
      A_ALM_HOUR: reg_rdata = alm_q[1];
      A_ALM_DAY:  reg_rdata = alm_q[2];
      A_FORCE:    reg_rdata[DATA_W-1] = force_q;
      A_CMD: begin
        reg_rdata[B_TDF]   = tdf_q;
        reg_rdata[B_WAF]   = waf_q;
        reg_rdata[B_TDM]   = ctrl_q.tdm;
        reg_rdata[B_WAM]   = ctrl_q.wam;
        reg_rdata[B_PULSE] = ctrl_q.pulse;
        reg_rdata[B_SEL]   = ctrl_q.sel;
      end
      default: ;
    endcase
  end

  assign alm_f   = alm_q;
  assign force_p = force_q;
  assign ctrl    = ctrl_q;
  assign tdf     = tdf_q;
  assign waf     = waf_q;

  // R4: the time-of-day flag only rises after a minute tick
  p_tdf_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdf_q) |-> $past(minute_tick));
  // R6: a command read with no competing set leaves the flag clear
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(minute_tick && hit)) |=> !tdf_q);
  // R5: the watchdog flag holds until it is read
  p_waf_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (waf_q && !flag_clr) |=> waf_q);
endmodule

// File: rtl/tod_irq_shaper.sv
module tod_irq_shaper #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_mode,
  input  logic flag,
  input  logic mask,
  input  logic fire,
  input  logic clr,
  output logic line
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;

  assign cnt_en = fire | clr | (cnt_q != '0);

  always_comb begin
    cnt_nx = cnt_q;
    if (fire)             cnt_nx = LOAD;
    else if (clr)         cnt_nx = '0;
    else if (cnt_q != '0) cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  assign line = pulse_mode ? (cnt_q != '0) : (flag & ~mask);

  // R8: a firing event loads the full pulse length
  p_pulse_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == LOAD));
  // R8: the pulse counter never exceeds its length
  p_pulse_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_day,
  input  logic              minute_tick,
  input  logic              wdog_evt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [5:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              tod_flag,
  output logic              wd_flag,
  output logic              irq_a_n,
  output logic              irq_b_n,
  output logic              irq_p_n
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [N_FIELD-1:0][DATA_W-1:0] cur_f, alm_f;
  logic  hit, force_p, tdf, waf, tod_fire, wd_fire, flag_clr;
  ctrl_t ctrl;

  assign cur_f[0] = cur_min;
  assign cur_f[1] = cur_hour;
  assign cur_f[2] = cur_day;

  tod_alarm_match u_match (
    .cur_f (cur_f),
    .alm_f (alm_f),
    .hit   (hit)
  );

  tod_alarm_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .minute_tick (minute_tick),
    .hit         (hit),
    .wdog_evt    (wdog_evt),
    .alm_f       (alm_f),
    .force_p     (force_p),
    .ctrl        (ctrl),
    .tdf         (tdf),
    .waf         (waf),
    .tod_fire    (tod_fire),
    .wd_fire     (wd_fire),
    .flag_clr    (flag_clr),
    .reg_rdata   (reg_rdata)
  );

  // source 0: time of day, source 1: watchdog
  logic [1:0] src_flag, src_mask, src_fire, src_line;
  assign src_flag = {waf, tdf};
  assign src_mask = {ctrl.wam, ctrl.tdm};
  assign src_fire = {wd_fire, tod_fire};

  generate
    for (genvar gs = 0; gs < 2; gs++) begin : g_src
      tod_irq_shaper #(.PULSE_LEN(PULSE_LEN)) u_shaper (
        .clk        (clk),
        .rst_n      (rst_i_n),
        .pulse_mode (ctrl.pulse),
        .flag       (src_flag[gs]),
        .mask       (src_mask[gs]),
        .fire       (src_fire[gs]),
        .clr        (flag_clr),
        .line       (src_line[gs])
      );
    end
  endgenerate

  logic line_a, line_b;
  assign line_a = ctrl.sel ? src_line[1] : src_line[0];
  assign line_b = ctrl.sel ? src_line[0] : src_line[1];

  assign irq_a_n  = ~line_a;
  assign irq_b_n  = ~line_b;
  assign irq_p_n  = ~(line_a | force_p);
  assign tod_flag = tdf;
  assign wd_flag  = waf;

  // R10: with force clear, pin P mirrors pin A
  p_p_follows_a_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !force_p |-> (irq_p_n == irq_a_n));
  // R10: force bit holds pin P low
  p_p_forced_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    force_p |-> !irq_p_n);
  // R9: a pin can only be active if some source line is active
  p_pins_sourced_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!irq_a_n || !irq_b_n) |-> (src_line != 2'b00));
endmodule

// File: tb/tod_alarm_unit_test.sv
`timescale 1ns/1ps
module tod_alarm_unit_test;
  localparam int PL = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] cmin, chour, cday, wdata;
  logic tick, wde, wr, rd;
  logic [5:0] addr;
  logic [7:0] rdata;
  logic tflag, wflag, a_n, b_n, p_n;

  always #4 clk = ~clk;

  tod_alarm_unit #(.PULSE_LEN(PL)) uut (
    .clk(clk), .rst_n(rst_n), .cur_min(cmin), .cur_hour(chour), .cur_day(cday),
    .minute_tick(tick), .wdog_evt(wde), .reg_wr(wr), .reg_rd(rd),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .tod_flag(tflag), .wd_flag(wflag), .irq_a_n(a_n), .irq_b_n(b_n), .irq_p_n(p_n)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  logic [7:0] m_alm[3];
  logic m_force, m_tdm, m_wam, m_pulse, m_sel, m_tdf, m_waf;
  int   m_cnt[2];

  task automatic model_reset();
    for (int i = 0; i < 3; i++) m_alm[i] = 8'h00;
    m_force = 0; m_tdm = 1; m_wam = 1; m_pulse = 0; m_sel = 0;
    m_tdf = 0; m_waf = 0; m_cnt[0] = 0; m_cnt[1] = 0;
  endtask

  function automatic logic fld_ok(logic [7:0] a, logic [7:0] c);
    return a[7] || (a[6:0] == c[6:0]);
  endfunction

  task automatic model_step();
    logic match, tset, clr, fire_t, fire_w;
    match  = fld_ok(m_alm[0], cmin) && fld_ok(m_alm[1], chour) && fld_ok(m_alm[2], cday);
    tset   = tick && match;
    clr    = rd && (addr == 6'h0B);
    fire_t = tset && !m_tdf && !m_tdm;
    fire_w = wde && !m_waf && !m_wam;
    if (fire_t) m_cnt[0] = PL; else if (clr) m_cnt[0] = 0; else if (m_cnt[0] > 0) m_cnt[0]--;
    if (fire_w) m_cnt[1] = PL; else if (clr) m_cnt[1] = 0; else if (m_cnt[1] > 0) m_cnt[1]--;
    if (clr) begin m_tdf = 0; m_waf = 0; end
    if (tset) m_tdf = 1;
    if (wde)  m_waf = 1;
    if (wr) begin
      case (addr)
        6'h03: m_alm[0] = wdata;
        6'h05: m_alm[1] = wdata;
        6'h07: m_alm[2] = wdata;
        6'h08: m_force  = wdata[7];
        6'h0B: begin
          m_tdm = wdata[2]; m_wam = wdata[3]; m_pulse = wdata[4]; m_sel = wdata[5];
        end
        default: ;
      endcase
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    case (addr)
      6'h03: return m_alm[0];
      6'h05: return m_alm[1];
      6'h07: return m_alm[2];
      6'h08: return {m_force, 7'b0};
      6'h0B: return {2'b00, m_sel, m_pulse, m_wam, m_tdm, m_waf, m_tdf};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic lt, lw, la, lb;
    lt = m_pulse ? (m_cnt[0] != 0) : (m_tdf && !m_tdm);
    lw = m_pulse ? (m_cnt[1] != 0) : (m_waf && !m_wam);
    la = m_sel ? lw : lt;
    lb = m_sel ? lt : lw;
    chk("rdata", rdata, exp_rdata());
    chk("tod_flag", {7'b0, tflag}, {7'b0, m_tdf});
    chk("wd_flag", {7'b0, wflag}, {7'b0, m_waf});
    chk("irq_a_n", {7'b0, a_n}, {7'b0, !la});
    chk("irq_b_n", {7'b0, b_n}, {7'b0, !lb});
    chk("irq_p_n", {7'b0, p_n}, {7'b0, !(la || m_force)});
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    compare_all();
    wr = 0; rd = 0; tick = 0; wde = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wreg(logic [5:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1; step();
  endtask

  task automatic rcmd();
    addr = 6'h0B; rd = 1; step();
  endtask

  task automatic tick_at(logic [7:0] m, logic [7:0] h, logic [7:0] d);
    cmin = m; chour = h; cday = d; tick = 1; step();
  endtask

  initial begin
    rst_n = 0; wr = 0; rd = 0; tick = 0; wde = 0;
    addr = 6'h0B; wdata = 0; cmin = 0; chour = 0; cday = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3);
    // R1 reset state
    cur_req = "R1"; addr = 6'h0B; idle(1);
    chk("R1 cmd reset value", rdata, 8'h0C);
    addr = 6'h03; idle(1);

    // R2 register access
    cur_req = "R2";
    wreg(6'h03, 8'h25); wreg(6'h05, 8'h14); wreg(6'h07, 8'h03);
    wreg(6'h08, 8'h7F); addr = 6'h08; idle(1);
    chk("R2 force keeps bit7 only", rdata, 8'h00);
    addr = 6'h10; idle(1);
    addr = 6'h05; idle(1);
    chk("R2 hour readback", rdata, 8'h14);

    // R3 / R4 match and tick
    cur_req = "R4";
    cmin = 8'h25; chour = 8'h14; cday = 8'h03; idle(2);
    chk("R4 no tick no flag", {7'b0, tflag}, 8'h00);
    cur_req = "R3";
    tick_at(8'h26, 8'h14, 8'h03);
    chk("R3 mismatch minute", {7'b0, tflag}, 8'h00);
    tick_at(8'h25, 8'h14, 8'h04);
    tick_at(8'h25, 8'h14, 8'h03);
    chk("R3 full match sets flag", {7'b0, tflag}, 8'h01);

    // R7 level mode, masks
    cur_req = "R7";
    wreg(6'h0B, 8'h08); idle(2);
    chk("R7 pin A active", {7'b0, a_n}, 8'h00);
    wreg(6'h0B, 8'h0C); idle(1);
    wreg(6'h0B, 8'h00);
    // R6 read clears
    cur_req = "R6"; rcmd(); idle(1);
    chk("R6 cleared", {7'b0, tflag}, 8'h00);

    // R5 watchdog flag and read-only bits
    cur_req = "R5";
    wde = 1; step(); idle(1);
    chk("R5 watchdog flag", {7'b0, wflag}, 8'h01);
    rcmd();
    wreg(6'h0B, 8'h03); addr = 6'h0B; idle(1);
    chk("R5 flag bits unwritable", rdata, 8'h00);

    // R9 swap
    cur_req = "R9";
    wde = 1; step();
    wreg(6'h0B, 8'h20); idle(2);
    chk("R9 swapped A", {7'b0, a_n}, 8'h00);
    rcmd();

    // R10 force
    cur_req = "R10";
    wreg(6'h08, 8'h80); idle(1);
    chk("R10 forced P", {7'b0, p_n}, 8'h00);
    wreg(6'h08, 8'h00); idle(1);
    wreg(6'h0B, 8'h00);
    wde = 1; step(); idle(1);
    rcmd();

    // R4 all masked fires each tick
    cur_req = "R4";
    wreg(6'h03, 8'h80); wreg(6'h05, 8'h80); wreg(6'h07, 8'h80);
    for (int k = 0; k < 3; k++) begin
      tick_at(8'(k * 7), 8'h09, 8'h02); rcmd();
    end

    // R8 pulse mode
    cur_req = "R8";
    wreg(6'h0B, 8'h10);
    tick_at(8'h11, 8'h01, 8'h01); idle(PL + 2);
    tick_at(8'h12, 8'h01, 8'h01); idle(2);
    rcmd(); idle(1);
    tick_at(8'h13, 8'h01, 8'h01);
    // R6 read and tick together while flag set: flag stays, no new pulse
    cur_req = "R6";
    idle(PL);
    addr = 6'h0B; rd = 1; cmin = 8'h14; tick = 1; step();
    chk("R6 set wins", {7'b0, tflag}, 8'h01);
    idle(PL + 1);
    rcmd(); idle(2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule